// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block gives an instruction-fetch unit a guess for the next fetch address. On every cycle the fetch stage presents its current address. The block splits the address into a table index and a tag, then reads one entry of a small direct-mapped table of recently executed branches. If the entry is valid, its tag matches and its two-bit history favours "taken", the stored target goes out as the predicted next fetch address. The lookup is combinational, so the prediction is ready in the same cycle as the fetch address.

The execute stage sends each resolved branch back through an update port: its address, its target and its outcome. A branch that is already in the table moves its history one step toward the outcome. A taken branch that is not in the table takes over the entry at its index. A registered enable input turns the whole block on and off. A flush input empties the table, for example whenever the instruction cache is invalidated.

Top module: `branch_target_table`

## Requirements
- R1: The table has 128 entries, direct mapped, and fetch-address bits [8:2] select the entry for both lookup and update.
- R2: A lookup hits only if the entry is valid and its stored tag equals fetch-address bits [31:9] together with bit 1. Two addresses that differ only in bit 1 therefore never share a hit.
- R3: History encoding is 2'b00 strongly not-taken, 2'b01 weakly not-taken, 2'b10 weakly taken and 2'b11 strongly taken. `pred_taken` is 1 only on a hit whose history is 2'b10 or 2'b11. In that case `pred_pc` equals the stored target bits [31:1] with bit 0 forced to 0. Otherwise `pred_pc` is 0.
- R4: A taken update that misses replaces the entry at its index with the new tag and target, and sets its history to weakly taken.
- R5: A not-taken update that misses leaves the table unchanged.
- R6: An update that hits moves the history one step toward the outcome, saturating at 2'b00 and 2'b11. The stored target is left as it is.
- R7: After synchronous active-low reset the block is disabled and every entry is invalid.
- R8: `bt_en` is registered. Predictions and updates take effect only in cycles after an edge at which `bt_en` was sampled high. Table contents survive while the block is disabled.
- R9: `flush_all` clears every valid bit at the next edge and overrides an update presented in the same cycle.
- R10: An update changes the table at the clock edge. A lookup in the same cycle sees the old contents, and the next cycle sees the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bt_en | input | 1 | Block enable, takes effect one cycle after it is sampled |
| flush_all | input | 1 | Invalidate every entry at the next edge |
| fetch_pc | input | 32 | Current fetch address |
| pred_taken | output | 1 | A taken prediction is made this cycle |
| pred_pc | output | 32 | Predicted next fetch address, 0 when no prediction |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Target of the resolved branch (bit 0 ignored) |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
A lookup result depends on the current fetch address within the same cycle. The bench therefore checks it shortly after the falling edge, before the next rising edge. Updates, flushes and reset act on the rising edge, and an enable change is seen one edge later than it is driven. For this reason the bench model applies each such stimulus at the edge and compares outputs only in the following cycle. Lookups made in the cycle of an update confirm that the old contents are still seen.

// File: rtl/btb_pkg.sv
// Shared types for the branch target table.
// Assumes the two-bit history is a saturating counter whose upper bit means "taken".
package btb_pkg;

    typedef enum logic [1:0] {
        HIST_SNT = 2'b00,
        HIST_WNT = 2'b01,
        HIST_WT  = 2'b10,
        HIST_ST  = 2'b11
    } hist_t;

    // True when a history state favours the taken direction.
    function automatic logic hist_favours_taken(hist_t h);
        return (h == HIST_WT) || (h == HIST_ST);
    endfunction

endpackage

// File: rtl/btb_addr_split.sv
// Splits an instruction address into the table index and the comparison tag.
// Assumes IDX_LSB == 2, so that bit 1 sits below the index and joins the tag.
// Bit 0 is never used.
module btb_addr_split #(
    parameter int ADDR_W  = 32,
    parameter int IDX_LSB = 2,
    parameter int IDX_W   = 7,
    localparam int TAG_W  = ADDR_W - IDX_LSB - IDX_W + 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);

    logic unused_lsb;

    // Index and tag fields.
    assign idx = addr[IDX_LSB +: IDX_W];
    assign tag = {addr[ADDR_W-1:IDX_LSB+IDX_W], addr[1]};

    // Bit 0 carries no information for halfword-aligned code.
    assign unused_lsb = addr[0];

endmodule

// File: rtl/btb_hist_step.sv
// Next state of a two-bit saturating history counter for one resolved outcome.
// Purely combinational.
module btb_hist_step
    import btb_pkg::*;
(
    input  hist_t cur,
    input  logic  taken,
    output hist_t nxt
);

    // One step toward the outcome, holding at either end.
    always_comb begin
        unique case (cur)
            HIST_SNT: nxt = taken ? HIST_WNT : HIST_SNT;
            HIST_WNT: nxt = taken ? HIST_WT  : HIST_SNT;
            HIST_WT:  nxt = taken ? HIST_ST  : HIST_WNT;
            default:  nxt = taken ? HIST_ST  : HIST_WT;
        endcase
    end

endmodule

// File: rtl/btb_table.sv
// Entry storage: a valid bit, a tag, a target and a history per entry.
// There are two combinational read ports (fetch and update) and one write port.
// Assumes only one write per cycle. clr_all and reset act on valid bits only.
module btb_table
    import btb_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int TAG_W = 24,
    parameter int TGT_W = 31,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    // fetch read port
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [TGT_W-1:0] rd_tgt,
    output hist_t            rd_hist,
    // update read port
    input  logic [IDX_W-1:0] chk_idx,
    output logic             chk_valid,
    output logic [TAG_W-1:0] chk_tag,
    output hist_t            chk_hist,
    // write port
    input  logic             wr_en,
    input  logic             wr_alloc,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TGT_W-1:0] wr_tgt,
    input  hist_t            wr_hist
);

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [TGT_W-1:0]   tgt_q  [ENTRIES];
    hist_t              hist_q [ENTRIES];

    // Valid bits: cleared by reset or flush, set by an allocation.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            valid_q <= '0;
        end else if (wr_en && wr_alloc) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Payload: tag and target on allocation, history on every write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            hist_q[wr_idx] <= wr_hist;
            if (wr_alloc) begin
                tag_q[wr_idx] <= wr_tag;
                tgt_q[wr_idx] <= wr_tgt;
            end
        end
    end

    // Fetch-side read.
    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_tgt   = tgt_q[rd_idx];
    assign rd_hist  = hist_q[rd_idx];

    // Update-side read.
    assign chk_valid = valid_q[chk_idx];
    assign chk_tag   = tag_q[chk_idx];
    assign chk_hist  = hist_q[chk_idx];

endmodule

// File: rtl/branch_target_table.sv
// Direct-mapped branch target buffer.
// The combinational lookup on fetch_pc gives a same-cycle prediction.
// The update port trains or allocates entries at the clock edge.
// Assumes halfword-aligned instructions and one update per cycle.
module branch_target_table
    import btb_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IDX_LSB = 2,
    parameter int IDX_W   = 7,
    localparam int TAG_W  = ADDR_W - IDX_LSB - IDX_W + 1,
    localparam int TGT_W  = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bt_en,
    input  logic              flush_all,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_pc,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              upd_taken
);

    logic             en_q;
    logic [IDX_W-1:0] f_idx, u_idx;
    logic [TAG_W-1:0] f_tag, u_tag;
    logic             rd_valid, chk_valid;
    logic [TAG_W-1:0] rd_tag, chk_tag;
    logic [TGT_W-1:0] rd_tgt;
    hist_t            rd_hist, chk_hist, stepped;
    logic             f_hit, u_hit;
    logic             wr_en;
    hist_t            wr_hist;
    logic             unused_tgt_lsb;

    // Enable register: off after reset, follows bt_en one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= bt_en;
    end

    btb_addr_split #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_fsplit (
        .addr(fetch_pc), .idx(f_idx), .tag(f_tag)
    );

    btb_addr_split #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_usplit (
        .addr(upd_pc), .idx(u_idx), .tag(u_tag)
    );

    btb_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_table (
        .clk(clk), .rst_n(rst_n), .clr_all(flush_all),
        .rd_idx(f_idx), .rd_valid(rd_valid), .rd_tag(rd_tag),
        .rd_tgt(rd_tgt), .rd_hist(rd_hist),
        .chk_idx(u_idx), .chk_valid(chk_valid), .chk_tag(chk_tag),
        .chk_hist(chk_hist),
        .wr_en(wr_en), .wr_alloc(!u_hit), .wr_idx(u_idx), .wr_tag(u_tag),
        .wr_tgt(upd_target[ADDR_W-1:1]), .wr_hist(wr_hist)
    );

    btb_hist_step u_step (.cur(chk_hist), .taken(upd_taken), .nxt(stepped));

    // Fetch-side hit and prediction.
    always_comb begin
        f_hit      = en_q && rd_valid && (rd_tag == f_tag);
        pred_taken = f_hit && hist_favours_taken(rd_hist);
        pred_pc    = pred_taken ? {rd_tgt, 1'b0} : '0;
    end

    // Update decision: train on hit, allocate on taken miss, drop otherwise.
    always_comb begin
        u_hit   = chk_valid && (chk_tag == u_tag);
        wr_en   = en_q && upd_valid && !flush_all && (u_hit || upd_taken);
        wr_hist = u_hit ? stepped : HIST_WT;
    end

    // Target bit 0 is always zero for aligned code.
    assign unused_tgt_lsb = upd_target[0];

endmodule

// File: rtl/btb_checker.sv
// Temporal checks on the branch target table ports, attached by bind.
module btb_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bt_en,
    input logic              flush_all,
    input logic              upd_valid,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              pred_taken,
    input logic [ADDR_W-1:0] pred_pc
);

    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> !pred_taken);

    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bt_en |=> !pred_taken);

    // R7
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !pred_taken);

    // R10
    hold_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n) && $past(bt_en, 2) && $past(bt_en)
         && $past(!upd_valid) && $past(!flush_all) && $stable(fetch_pc))
        |-> ($stable(pred_taken) && $stable(pred_pc)));

endmodule

bind branch_target_table btb_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bt_en(bt_en), .flush_all(flush_all),
    .upd_valid(upd_valid), .fetch_pc(fetch_pc),
    .pred_taken(pred_taken), .pred_pc(pred_pc)
);

// File: tb/branch_target_table_test.sv
module branch_target_table_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, bt_en, flush_all, upd_valid, upd_taken;
    logic [31:0] fetch_pc, upd_pc, upd_target, pred_pc;
    logic        pred_taken;

    branch_target_table uut (
        .clk(clk), .rst_n(rst_n), .bt_en(bt_en), .flush_all(flush_all),
        .fetch_pc(fetch_pc), .pred_taken(pred_taken), .pred_pc(pred_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target),
        .upd_taken(upd_taken)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model built from the requirements.
    bit          mv   [128];
    logic [23:0] mtag [128];
    logic [30:0] mtgt [128];
    logic [1:0]  mh   [128];
    bit          m_en;
    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done    = 0;

    function automatic logic [31:0] mk_pc(int idx, logic [22:0] hi, bit b1);
        return {hi, idx[6:0], b1, 1'b0};
    endfunction

    task automatic chk(string req, logic [32:0] act, logic [32:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: apply the model at the edge, then return after the falling edge.
    task automatic tick();
        bit nen;
        int i;
        logic [23:0] t;
        nen = rst_n ? bt_en : 1'b0;
        if (!rst_n || flush_all) begin
            for (int k = 0; k < 128; k++) mv[k] = 0;
        end else if (m_en && upd_valid) begin
            i = int'(upd_pc[8:2]);
            t = {upd_pc[31:9], upd_pc[1]};
            if (mv[i] && mtag[i] == t) begin
                if (upd_taken) mh[i] = (mh[i] == 2'b11) ? 2'b11 : mh[i] + 2'b01;
                else           mh[i] = (mh[i] == 2'b00) ? 2'b00 : mh[i] - 2'b01;
            end else if (upd_taken) begin
                mv[i] = 1; mtag[i] = t; mtgt[i] = upd_target[31:1]; mh[i] = 2'b10;
            end
        end
        @(posedge clk);
        m_en = nen;
        @(negedge clk);
    endtask

    task automatic look(logic [31:0] a, string req);
        int i;
        bit hit;
        fetch_pc = a;
        #1;
        i = int'(a[8:2]);
        hit = m_en && mv[i] && (mtag[i] == {a[31:9], a[1]}) && mh[i][1];
        chk(req, {pred_taken, pred_pc}, {hit, hit ? {mtgt[i], 1'b0} : 32'h0});
    endtask

    task automatic upd(logic [31:0] pc, logic [31:0] tgt, bit tk);
        upd_valid = 1; upd_pc = pc; upd_target = tgt; upd_taken = tk;
        tick();
        upd_valid = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] pa, pb;
        bit seq [9];
        rst_n = 0; bt_en = 0; flush_all = 0; upd_valid = 0; upd_taken = 0;
        fetch_pc = 0; upd_pc = 0; upd_target = 0; m_en = 0;
        for (int k = 0; k < 128; k++) begin mv[k] = 0; mh[k] = 0; mtag[k] = 0; mtgt[k] = 0; end
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1;

        // R7: no prediction out of reset
        look(32'h0000_0000, "R7");
        look(32'hFFFF_FFFE, "R7");
        // R8: update while disabled is dropped
        pa = mk_pc(3, 23'h0ABCD, 0);
        upd(pa, 32'h0000_4000, 1);
        bt_en = 1;
        look(pa, "R8");        // enable not yet registered
        tick();
        look(pa, "R8");        // enabled, entry was never written

        // R1 R4 R10: allocate one taken branch per index
        for (int i = 0; i < 128; i++) begin
            pa = mk_pc(i, 23'(i * 32'h1357 + 5), i[0]);
            fetch_pc = pa;
            upd_valid = 1; upd_pc = pa; upd_target = i * 32'h0012_3457 + 32'h100; upd_taken = 1;
            if (i == 5) look(pa, "R10");   // same-cycle lookup sees old contents
            tick();
            upd_valid = 0;
            if (i == 5) look(pa, "R10");
        end
        for (int i = 0; i < 128; i++) begin
            pa = mk_pc(i, 23'(i * 32'h1357 + 5), i[0]);
            look(pa, "R1");
            look(pa ^ 32'h2, "R2");          // bit 1 differs
            look(pa ^ 32'h8000_0000, "R2");  // upper tag differs
        end

        // R6 and R3: history walk on index 10
        pa = mk_pc(10, 23'(10 * 32'h1357 + 5), 0);
        seq = '{0, 0, 0, 1, 1, 1, 1, 0, 0};
        foreach (seq[k]) begin
            upd(pa, 32'h7777_0000, seq[k]);  // target must not change on a hit
            look(pa, "R6");
        end
        look(pa, "R3");

        // R5: not-taken miss leaves the entry alone
        pa = mk_pc(20, 23'(20 * 32'h1357 + 5), 0);
        pb = mk_pc(20, 23'h7F00F, 1);
        upd(pb, 32'h0000_0200, 0);
        look(pa, "R5");
        look(pb, "R5");

        // R4: taken miss replaces and starts weakly taken
        pa = mk_pc(30, 23'(30 * 32'h1357 + 5), 0);
        pb = mk_pc(30, 23'h12345, 0);
        upd(pb, 32'h00AB_CDE2, 1);
        look(pa, "R4");
        look(pb, "R4");
        upd(pb, 32'h0, 0);
        look(pb, "R4");

        // R8: disable stops predictions, drops updates, keeps contents
        pa = mk_pc(40, 23'(40 * 32'h1357 + 5), 0);
        bt_en = 0;
        look(pa, "R8");
        tick();
        look(pa, "R8");
        upd(pa, 32'h0, 0);
        upd(pa, 32'h0, 0);
        bt_en = 1;
        tick();
        look(pa, "R8");

        // R9: flush overrides a same-cycle allocation
        flush_all = 1;
        upd(mk_pc(50, 23'h00FFF, 0), 32'h0000_1230, 1);
        flush_all = 0;
        look(mk_pc(50, 23'h00FFF, 0), "R9");
        for (int i = 0; i < 128; i++) look(mk_pc(i, 23'(i * 32'h1357 + 5), i[0]), "R9");
        pa = mk_pc(60, 23'h00042, 1);
        upd(pa, 32'h0000_0ABE, 1);
        look(pa, "R9");

        // R7: reset mid-run empties the table
        rst_n = 0;
        tick();
        rst_n = 1;
        look(pa, "R7");
        tick();
        look(pa, "R7");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule